// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block gives software a bank of 32 general-purpose pins through three word-wide registers on a simple register bus. The bus has a word address, a write strobe with write data, and a read strobe. The three registers are a direction register, an open-drain enable register and an output data register. From these the block derives a per-pin output enable and output value for the pad ring. Pad levels enter through a two-flop synchronizer before software can see them.

Pins are numbered from the most significant end: pin n lives in register bit 31-n. Open-drain pins only ever pull low, and release the pad to signal a one.

Two elaboration options change behaviour:
- `READ_DRIVEN` selects whether output pins read back their stored output value or the synchronized pad level.
- `INPUT_ONLY_EN` makes pins 28 to 31 permanently inputs.

Both options are on by default.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the direction, open-drain and data registers are all zero, every `pad_oe` bit is 0 and every `pad_out` bit is 0.
- R2: A direction bit of 1 makes the pin an output and a 0 makes it an input. An input pin never asserts `pad_oe`.
- R3: Pin n corresponds to bit (31 - n) of every register, of `pad_oe`, `pad_out` and `pad_in`. Pin 0 is bit 31 and pin 5 is bit 26.
- R4: The word offsets are decoded on `bus_addr`: direction at 0x00, open-drain enable at 0x04, data at 0x08. A write to any other offset changes nothing, and a read of any other offset returns 0.
- R5: An output pin with its open-drain bit set does two things. With data 0 it asserts `pad_oe` with `pad_out` 0. With data 1 it deasserts `pad_oe`.
- R6: An output pin with its open-drain bit clear asserts `pad_oe` and drives `pad_out` equal to its data bit. `pad_out` is 0 whenever `pad_oe` is 0.
- R7: A data-register read returns the pad level for input pins, taken after a two-flop synchronizer. A `pad_in` change made before clock edge k becomes visible in a read sampled at edge k+2.
- R8: With `READ_DRIVEN`=1 (default), a data read returns the stored data bit for output pins. With `READ_DRIVEN`=0, it returns the synchronized pad level for every pin.
- R9: With `INPUT_ONLY_EN`=1 (default), pins 28 to 31 (bits 3..0) ignore direction writes of 1. Their direction bits read 0 and their `pad_oe` stays 0.
- R10: A data-register write stores all 32 bits, including bits of pins that are currently inputs. Such bits are driven once those pins become outputs.
- R11: `bus_rdata` is registered. It takes the addressed value at the clock edge where `bus_rd` is high and holds that value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the word register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | NUM_PINS (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | NUM_PINS (32) | Registered read data |
| pad_in | input | NUM_PINS (32) | Pad levels, asynchronous |
| pad_oe | output | NUM_PINS (32) | Per-pin output enable |
| pad_out | output | NUM_PINS (32) | Per-pin output value |

## Verification
Register writes reach `pad_oe` and `pad_out` at the clock edge that samples the write strobe. Read data appears one edge after the read strobe is sampled. A pad change needs two further edges before a read can capture it.

The bench drives inputs on falling edges and samples on the following falling edge. This places every check half a cycle after the edge that is due to produce the result. The synchronizer test holds the read strobe high across the pad change. It then checks the read value after each of the three following edges: zero after the first two, and the new pad level after the third.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned OFS_DIR = 'h00;
   localparam int unsigned OFS_ODE = 'h04;
   localparam int unsigned OFS_DAT = 'h08;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_DIR,
      SEL_ODE,
      SEL_DAT
   } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl (
   input  logic dir,
   input  logic open_drain,
   input  logic dat,
   output logic oe,
   output logic out
);
   // Open-drain pins release the pad for a one and pull low for a zero.
   assign oe  = dir & ~(open_drain & dat);
   assign out = oe & dat;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_PINS         = 32,
   parameter int unsigned ADDR_W           = 8,
   parameter int unsigned SYNC_STAGES      = 2,
   parameter bit          READ_DRIVEN      = 1'b1,
   parameter bit          INPUT_ONLY_EN    = 1'b1,
   parameter int unsigned INPUT_ONLY_FIRST = 28
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [NUM_PINS-1:0] bus_wdata,
   input  logic                bus_rd,
   output logic [NUM_PINS-1:0] bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out
);
   localparam int unsigned MSB = NUM_PINS - 1;

   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
      $error("gpio_port_regs: NUM_PINS must lie in 1..32");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("gpio_port_regs: ADDR_W too small for the register offsets");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port_regs: SYNC_STAGES must be at least 2");
   end
   if (INPUT_ONLY_FIRST > NUM_PINS) begin : g_bad_lock
      $error("gpio_port_regs: INPUT_ONLY_FIRST beyond the last pin");
   end

   logic [NUM_PINS-1:0] dir_q, od_q, dat_q;
   logic [NUM_PINS-1:0] dir_wmask;
   logic [NUM_PINS-1:0] pad_sync;
   logic [NUM_PINS-1:0] dat_view;
   reg_sel_e            sel;

   // Register bit b carries pin (MSB - b).
   for (genvar b = 0; b < NUM_PINS; b++) begin : g_bit
      localparam int unsigned PIN = MSB - b;
      if (INPUT_ONLY_EN && PIN >= INPUT_ONLY_FIRST) begin : g_locked
         assign dir_wmask[b] = 1'b0;
      end else begin : g_free
         assign dir_wmask[b] = 1'b1;
      end

      gpio_pin_ctrl u_pin (
         .dir        (dir_q[b]),
         .open_drain (od_q[b]),
         .dat        (dat_q[b]),
         .oe         (pad_oe[b]),
         .out        (pad_out[b])
      );
   end

   always_comb begin
      if (bus_addr == ADDR_W'(OFS_DIR))      sel = SEL_DIR;
      else if (bus_addr == ADDR_W'(OFS_ODE)) sel = SEL_ODE;
      else if (bus_addr == ADDR_W'(OFS_DAT)) sel = SEL_DAT;
      else                                   sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         od_q  <= '0;
         dat_q <= '0;
      end else if (bus_wr) begin
         case (sel)
            SEL_DIR: dir_q <= bus_wdata & dir_wmask;
            SEL_ODE: od_q  <= bus_wdata;
            SEL_DAT: dat_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   gpio_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   if (READ_DRIVEN) begin : g_rd_driven
      assign dat_view = (dir_q & dat_q) | (~dir_q & pad_sync);
   end else begin : g_rd_pad
      assign dat_view = pad_sync;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         case (sel)
            SEL_DIR: bus_rdata <= dir_q;
            SEL_ODE: bus_rdata <= od_q;
            SEL_DAT: bus_rdata <= dat_view;
            default: bus_rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_PINS         = 32,
   parameter int unsigned ADDR_W           = 8,
   parameter bit          INPUT_ONLY_EN    = 1'b1,
   parameter int unsigned INPUT_ONLY_FIRST = 28
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [NUM_PINS-1:0] bus_wdata,
   input logic [NUM_PINS-1:0] dir_q,
   input logic [NUM_PINS-1:0] od_q,
   input logic [NUM_PINS-1:0] dat_q,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_out
);
   function automatic logic [NUM_PINS-1:0] lock_bits();
      logic [NUM_PINS-1:0] m = '0;
      for (int p = 0; p < NUM_PINS; p++)
         if (INPUT_ONLY_EN && p >= INPUT_ONLY_FIRST) m[NUM_PINS-1-p] = 1'b1;
      return m;
   endfunction

   localparam logic [NUM_PINS-1:0] LOCKED = lock_bits();

   AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~dir_q) == '0);                                        // R2
   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_out & od_q) == '0);                                // R5
   AST_PUSH_PULL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q & ~od_q & (pad_out ^ dat_q)) == '0);                      // R6
   AST_LOCKED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & LOCKED) == '0);                                        // R9
   AST_DATA_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_DAT)) |=> dat_q == $past(bus_wdata)); // R10
endmodule

bind gpio_port_regs gpio_port_chk #(
   .NUM_PINS         (NUM_PINS),
   .ADDR_W           (ADDR_W),
   .INPUT_ONLY_EN    (INPUT_ONLY_EN),
   .INPUT_ONLY_FIRST (INPUT_ONLY_FIRST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .dir_q     (dir_q),
   .od_q      (od_q),
   .dat_q     (dat_q),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out)
);

// File: tb/sim_gpio_port_regs.sv
`timescale 1ns/1ps
module sim_gpio_port_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_oe, pad_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_port_regs u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   // {addr, wdata, expected pad_oe, expected pad_out, expected read of addr}; pad_in = 0
   localparam int NV = 8;
   localparam logic [135:0] VEC [NV] = '{
      {8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'h0000_0000, 32'hFFFF_FFF0},
      {8'h08, 32'hA5A5_5A5A, 32'hFFFF_FFF0, 32'hA5A5_5A50, 32'hA5A5_5A50},
      {8'h04, 32'h0000_FFFF, 32'hFFFF_A5A0, 32'hA5A5_0000, 32'h0000_FFFF},
      {8'h00, 32'h0F0F_0F0F, 32'h0F0F_0500, 32'h0505_0000, 32'h0F0F_0F00},
      {8'h08, 32'h0000_0000, 32'h0F0F_0F00, 32'h0000_0000, 32'h0000_0000},
      {8'h0C, 32'hFFFF_FFFF, 32'h0F0F_0F00, 32'h0000_0000, 32'h0000_0000},
      {8'h04, 32'h0000_0000, 32'h0F0F_0F00, 32'h0000_0000, 32'h0000_0000},
      {8'h00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 oe", pad_oe, 32'h0);
      check("R1 out", pad_out, 32'h0);
      rst_n = 1'b1;
      rd(8'h00, r); check("R1 dir", r, 32'h0);
      rd(8'h04, r); check("R1 od", r, 32'h0);
      rd(8'h08, r); check("R1 dat", r, 32'h0);

      // Vector walk: R2 R4 R5 R6 R9 R10
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][135:128], VEC[i][127:96]);
         check("R2/R5/R9 oe", pad_oe, VEC[i][95:64]);
         check("R5/R6 out", pad_out, VEC[i][63:32]);
         rd(VEC[i][135:128], r);
         check("R4 readback", r, VEC[i][31:0]);
      end

      // R3 pin numbering: pin 0 -> bit 31, pin 5 -> bit 26
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h00, 32'h8000_0000);
      check("R3 pin0", pad_oe, 32'h8000_0000);
      wr(8'h00, 32'h0400_0000);
      check("R3 pin5", pad_out, 32'h0400_0000);

      // R9 upper pins stay inputs
      wr(8'h00, 32'h0000_000F);
      check("R9 oe", pad_oe, 32'h0);
      rd(8'h00, r); check("R9 dir", r, 32'h0);

      // R10 data stored for input pins, driven once outputs
      wr(8'h00, 32'h0);
      wr(8'h08, 32'h8000_0001);
      check("R10 no drive", pad_oe, 32'h0);
      wr(8'h00, 32'h8000_0001);
      check("R10 oe", pad_oe, 32'h8000_0000);
      check("R10 out", pad_out, 32'h8000_0000);

      // R7 two-flop synchronizer, read strobe held
      wr(8'h00, 32'h0);
      @(negedge clk);
      bus_addr = 8'h08; bus_rd = 1'b1;
      @(negedge clk);
      pad_in = 32'h1234_5678;
      @(negedge clk); check("R7 edge1", bus_rdata, 32'h0);
      @(negedge clk); check("R7 edge2", bus_rdata, 32'h0);
      @(negedge clk); check("R7 edge3", bus_rdata, 32'h1234_5678);
      bus_rd = 1'b0;

      // R11 read data holds without strobe
      pad_in = 32'hDEAD_BEEF;
      wr(8'h08, 32'h0);
      repeat (3) @(negedge clk);
      check("R11 hold", bus_rdata, 32'h1234_5678);

      // R8 output pins read stored value, input pins read pad
      pad_in = 32'hFFFF_FFFF;
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h08, 32'h0000_0000);
      repeat (3) @(negedge clk);
      rd(8'h08, r); check("R8 mixed", r, 32'h0000_000F);
      wr(8'h08, 32'h0F0F_0000);
      rd(8'h08, r); check("R8 stored", r, 32'h0F0F_000F);

      finish_run();
   end
endmodule